// File: doc/BRIEF.md
# Start-to-Done Latency Cycle Counter

This block measures how many clock cycles a neighbouring processing unit spends on one task. It observes two single-bit signals of that unit's block-level handshake: the start request sent to the unit and the done indication the unit raises when it finishes. The unit's idle and ready signals are not used. Each input goes through a rising-edge detector, so a level held high for several cycles counts as a single event.

A two-state controller sits idle until a start edge arrives. It then counts clock cycles until a done edge arrives. At that point the final count is written to a result register and a one-cycle valid strobe is raised. The result holds its value until the next measurement completes. The counter saturates at its all-ones value instead of wrapping, so an overlong task reports the maximum.

A typical use is to tie both inputs to the handshake of a block under test and read `lat_cycles` whenever `lat_valid` pulses.

Top module: `cyc_latency_meter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `measuring` is 0, `lat_valid` is 0 and `lat_cycles` is 0. Reset is synchronous and active high.
- R2: When `task_start` is sampled high at a clock edge after being sampled low at the previous edge (or at the first edge after reset), and the controller is idle, `measuring` is 1 after that edge.
- R3: If the start edge is accepted at clock edge E0, and done is first sampled high at edge E0+N (N ≥ 1), then after edge E0+N `lat_cycles` equals N and `lat_valid` is 1 for exactly one cycle.
- R4: A `task_start` or `task_done` level held high for several cycles counts as one event. A held start does not restart the measurement. A held done produces only one `lat_valid` pulse.
- R5: A rising edge on `task_done` while idle is ignored: no `lat_valid` pulse, and `lat_cycles` is unchanged.
- R6: A rising edge on `task_start` while counting is ignored: the measurement continues from the first start edge.
- R7: The count saturates at 2^CNT_W−1. A task that lasts N ≥ 2^CNT_W−1 cycles reports 2^CNT_W−1.
- R8: `lat_cycles` changes only on the edge that raises `lat_valid`, and otherwise holds its last value.
- R9: The controller state is visible on `measuring`: 0 for idle, 1 for counting. It returns to 0 on the edge that accepts done.
- R10: If start and done rise on the same edge while idle, start is accepted and done is ignored. If both rise on the same edge while counting, done ends the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_start | input | 1 | Start request observed on the measured unit |
| task_done | input | 1 | Done indication from the measured unit |
| measuring | output | 1 | 1 while a measurement is in progress |
| lat_valid | output | 1 | One-cycle strobe when a new result is written |
| lat_cycles | output | CNT_W | Last measured latency in clock cycles |

## Verification
A controller stuck in the wrong state shows up on `measuring` at the next negative edge. It also shows up as a missing or extra `lat_valid` pulse at the end of the task. An off-by-one in the counter or in the capture path shows as a wrong `lat_cycles` value on the very strobe that ends the measurement. A second instance with a 4-bit counter runs the same stimulus, so the saturation edge (a task of 14, 15 and 20 cycles) is reached within tens of cycles. A counter that wraps would report a small value there.

// File: rtl/lat_pkg.sv
package lat_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_COUNT = 1'b1
   } meter_state_t;

endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
   parameter int N_SIG = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SIG-1:0] lvl,
   output logic [N_SIG-1:0] rise
);

   if (N_SIG < 1) begin : g_bad_width
      $error("rise_detect: N_SIG must be at least 1");
   end

   for (genvar i = 0; i < N_SIG; i++) begin : g_bit
      logic prev_q;

      always_ff @(posedge clk) begin
         if (rst) prev_q <= 1'b0;
         else     prev_q <= lvl[i];
      end

      assign rise[i] = lvl[i] & ~prev_q;

      // R4: an event lasts one cycle however long the level is held
      a_r4_single_event: assert property (@(posedge clk) disable iff (rst)
         rise[i] |=> !rise[i]);
   end

endmodule

// File: rtl/meter_ctrl.sv
module meter_ctrl
   import lat_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic go_ev,
   input  logic end_ev,
   output logic clr_cnt,
   output logic inc_cnt,
   output logic capture,
   output logic busy
);

   meter_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      clr_cnt = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (go_ev) begin
               state_d = ST_COUNT;
               clr_cnt = 1'b1;
            end
         end
         ST_COUNT: begin
            if (end_ev) begin
               state_d = ST_IDLE;
               capture = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign inc_cnt = (state_q == ST_COUNT) && !end_ev;
   assign busy    = (state_q == ST_COUNT);

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   // R2: start edge in idle begins counting
   a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && go_ev) |=> (state_q == ST_COUNT));
   // R5: done edge in idle leaves the controller idle
   a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && end_ev && !go_ev) |=> (state_q == ST_IDLE));
   // R6: start edge while counting keeps counting
   a_r6_restart_ignored: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_COUNT && go_ev && !end_ev) |=> (state_q == ST_COUNT));
   // R9: done while counting returns to idle
   a_r9_done_exit: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_COUNT && end_ev) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_nxt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   assign cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst || clr) cnt_q <= '0;
      else if (inc)   cnt_q <= cnt_nxt;
   end

   // R7: the counter never wraps from its maximum
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));
   // R7: while incrementing the count never decreases
   a_r7_monotonic: assert property (@(posedge clk) disable iff (rst)
      (inc && !clr) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/result_hold.sv
module result_hold #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic [CNT_W-1:0] value,
   output logic [CNT_W-1:0] result,
   output logic             valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         valid  <= 1'b0;
      end else begin
         valid <= capture;
         if (capture) result <= value;
      end
   end

   // R3: the result strobe lasts a single cycle
   a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);
   // R8: result only moves together with the strobe
   a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
      !valid |-> $stable(result));

endmodule

// File: rtl/cyc_latency_meter.sv
module cyc_latency_meter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             task_start,
   input  logic             task_done,
   output logic             measuring,
   output logic             lat_valid,
   output logic [CNT_W-1:0] lat_cycles
);

   localparam int N_EV  = 2;
   localparam int EV_GO = 0;
   localparam int EV_END = 1;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
      $error("cyc_latency_meter: CNT_W must lie in 2..64");
   end

   logic [N_EV-1:0]  ev;
   logic             clr_cnt, inc_cnt, capture;
   logic [CNT_W-1:0] cnt_nxt;

   rise_detect #(.N_SIG(N_EV)) u_edges (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({task_done, task_start}),
      .rise (ev)
   );

   meter_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .go_ev   (ev[EV_GO]),
      .end_ev  (ev[EV_END]),
      .clr_cnt (clr_cnt),
      .inc_cnt (inc_cnt),
      .capture (capture),
      .busy    (measuring)
   );

   sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr_cnt),
      .inc     (inc_cnt),
      .cnt_nxt (cnt_nxt)
   );

   result_hold #(.CNT_W(CNT_W)) u_res (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .value   (cnt_nxt),
      .result  (lat_cycles),
      .valid   (lat_valid)
   );

   // R10 / R9: a strobe is always preceded by an active measurement
   a_r10_strobe_after_busy: assert property (@(posedge clk) disable iff (rst)
      lat_valid |-> !measuring || $past(measuring));

endmodule

// File: tb/test_cyc_latency_meter.sv
`timescale 1ns/1ps
module test_cyc_latency_meter;

   localparam int  W_BIG  = 32;
   localparam int  W_SML  = 4;
   localparam int  SMAX   = 15;
   localparam time T_CLK  = 20ns;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic done = 1'b0;

   logic             meas_b, vld_b, meas_s, vld_s;
   logic [W_BIG-1:0] res_b;
   logic [W_SML-1:0] res_s;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   int vld_seen = 0;

   int q_big[$];
   int q_sml[$];

   always #(T_CLK/2) clk = ~clk;

   cyc_latency_meter #(.CNT_W(W_BIG)) i_cyc_latency_meter (
      .clk(clk), .rst(rst), .task_start(start), .task_done(done),
      .measuring(meas_b), .lat_valid(vld_b), .lat_cycles(res_b));

   cyc_latency_meter #(.CNT_W(W_SML)) i_cyc_latency_meter_small (
      .clk(clk), .rst(rst), .task_start(start), .task_done(done),
      .measuring(meas_s), .lat_valid(vld_s), .lat_cycles(res_s));

   task automatic check(string req, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard monitor: compare each strobe against the queued expectation
   always @(negedge clk) begin
      if (!rst && !finished) begin
         if (vld_b) begin
            vld_seen++;
            if (q_big.size() == 0) check("R5 unexpected strobe (32b)", 1, 0);
            else check("R3 latency (32b)", res_b, q_big.pop_front());
         end
         if (vld_s) begin
            if (q_sml.size() == 0) check("R5 unexpected strobe (4b)", 1, 0);
            else check("R7 saturated latency (4b)", res_s, q_sml.pop_front());
         end
      end
   end

   // driver: start held sh cycles, done rises n cycles later held dh cycles,
   // optional extra start pulse at cycle xs while counting
   task automatic measure(int n, int sh, int dh, int xs);
      int last;
      q_big.push_back(n);
      q_sml.push_back(n > SMAX ? SMAX : n);
      last = (n + dh > sh) ? n + dh : sh;
      for (int i = 0; i <= last; i++) begin
         if (i == 1 && n > 1) check("R2/R9 measuring after start", meas_b, 1);
         start = (i < sh) || (i == xs);
         done  = (i >= n) && (i < n + dh);
         @(negedge clk);
      end
      start = 1'b0;
      done  = 1'b0;
      check("R9 idle after done", meas_b, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(T_CLK * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int held;
      @(negedge clk);
      @(negedge clk);
      // R1: reset values
      check("R1 measuring in reset", meas_b, 0);
      check("R1 valid in reset", vld_b, 0);
      check("R1 result in reset", res_b, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 measuring after reset", meas_b, 0);
      check("R1 result after reset", res_b, 0);

      // R3: the nominal 17-cycle task, plus short and other lengths
      measure(17, 1, 1, -1);
      measure(1, 1, 1, -1);
      measure(5, 1, 1, -1);
      // R8: result held while idle
      repeat (5) @(negedge clk);
      check("R8 result held", res_b, 5);

      // R4: start held 6 cycles, done held 4 cycles
      held = vld_seen;
      measure(10, 6, 4, -1);
      check("R4 one strobe for held done", vld_seen - held, 1);

      // R6: extra start edge at cycle 4 of a 9-cycle task
      measure(9, 1, 1, 4);

      // R5: done pulses while idle
      held = vld_seen;
      for (int k = 0; k < 3; k++) begin
         done = 1'b1; @(negedge clk);
         done = 1'b0; @(negedge clk);
      end
      repeat (2) @(negedge clk);
      check("R5 no strobe from idle done", vld_seen - held, 0);
      check("R5 result unchanged", res_b, 9);
      check("R5 still idle", meas_b, 0);

      // R10: start and done together in idle -> start wins, done at 7
      q_big.push_back(7);
      q_sml.push_back(7);
      start = 1'b1; done = 1'b1; @(negedge clk);
      start = 1'b0; done = 1'b0;
      check("R10 measuring after joint edges", meas_b, 1);
      repeat (6) @(negedge clk);
      done = 1'b1; @(negedge clk);
      done = 1'b0;
      check("R10 idle after done", meas_b, 0);
      repeat (3) @(negedge clk);

      // R7: saturation boundary on the 4-bit instance
      measure(14, 1, 1, -1);
      measure(15, 1, 1, -1);
      measure(20, 1, 1, -1);
      check("R7 small result saturated", res_s, SMAX);
      check("R7 wide result unsaturated", res_b, 20);

      repeat (4) @(negedge clk);
      check("R3 all results delivered (32b)", q_big.size(), 0);
      check("R7 all results delivered (4b)", q_sml.size(), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule